// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores received frames, one after another, in a circular byte buffer held in a local RAM. Each stored entry starts with a 4-byte header, followed by the frame bytes. While a frame is arriving, the header carries a placeholder length. When the frame ends, the header is rewritten with the final status word and byte count. Only after that rewrite does the write pointer move past the entry, to the next dword boundary. A host consumes entries up to the write pointer and reports its progress by writing a read pointer that is biased by 16.

The block compares the two pointers for two purposes. It raises an empty flag whenever they are equal. It also refuses, byte by byte, any frame that would leave less than one free dword in front of the reader. A refused frame is discarded and a sticky overflow interrupt is raised. The RAM is addressed in dwords with per-byte enables, so it maps onto a dual-port block RAM whose read side belongs to the host.

The buffer length is `BASE_BYTES << size_code`. With `BASE_BYTES = 8192` the four codes give 8K, 16K, 32K and 64K. The RAM is sized for the largest length plus 16 spare bytes.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_addr` is 0, the read address is 0, `buf_empty` is 1, `ovf_irq` is 0 and `mem_we` is 0.
- R2: The buffer length L is `BASE_BYTES << size_code`. Every byte address written is taken modulo L, so an entry that runs past the end continues at address 0.
- R3: One cycle after a frame's first byte is accepted, the block writes the header dword at `cur_addr` with all four byte enables set. Bytes 0–1 hold status 0x0000 and bytes 2–3 hold the placeholder length 0xFFF0, low byte first (data word 0xFFF00000).
- R4: Payload byte i of a frame is stored at byte address (`cur_addr` + 4 + i) mod L. Within a dword, byte lane k (data bits 8k+7:8k, enable bit k) holds the byte whose address has bits 1:0 equal to k.
- R5: After the last byte, the header is rewritten as {length, status}. The length is the number of payload bytes, CRC included, and sits in bytes 2–3. Only then does `cur_addr` become (`cur_addr` + round-up-to-4(4 + length)) mod L. `cur_addr` stays a multiple of 4 at all times.
- R6: A host write of value v sets the read address to (v + 16) mod L.
- R7: `buf_empty` is 1 exactly when `cur_addr` equals the read address. It follows a change of either pointer in the same cycle as that pointer's register.
- R8: Let free be (read − `cur_addr`) mod L, or L when the two are equal. The n-th byte of a frame is accepted only when round-up-to-4(4 + n) + 4 ≤ free. Otherwise the frame is dropped: nothing more of it is written, `cur_addr` stays where it was, and `ovf_irq` is set.
- R9: `ovf_irq` stays set until a cycle with `ovf_ack` high. If a new drop and `ovf_ack` occur in the same cycle, the flag is set.
- R10: A new frame may start on the third cycle after the previous frame's last byte. Two frames separated by exactly two idle cycles are both stored intact.
- R11: The status word is stored exactly as supplied with the last byte. Frames with error bits are stored like good ones. Bit 0 = received OK, bit 1 = alignment error, bit 2 = CRC error, bit 3 = too long, bit 4 = runt, bit 5 = invalid symbol.
- R12: A one-byte frame is stored correctly: its header, one payload byte, and an advance of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_code | input | 2 | Buffer length select, L = BASE_BYTES << size_code; change only under reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_status | input | 16 | Frame status, sampled with the last byte |
| rdp_we | input | 1 | Host read-pointer write strobe |
| rdp_wdata | input | 16 | Host read pointer, read address minus 16 |
| ovf_ack | input | 1 | Clears the overflow interrupt |
| mem_we | output | 1 | RAM write strobe |
| mem_be | output | 4 | RAM byte enables, lane k = bits 8k+7:8k |
| mem_addr | output | MEM_AW | RAM dword address |
| mem_wdata | output | 32 | RAM write data |
| cur_addr | output | 16 | Write pointer: byte address of the next entry |
| buf_empty | output | 1 | Write pointer equals read address |
| ovf_irq | output | 1 | Sticky buffer-overflow interrupt |

## Verification
The assertions take for granted that `rx_valid` stays low for the two cycles after `rx_last`, while the header rewrite is in flight. The stimulus keeps exactly that gap after each frame, and in one case starts the next frame on the first allowed cycle. They also assume that `size_code` changes only under reset, and that the host never moves its read pointer past the write pointer. The bench only ever writes the read pointer to `cur_addr - 16` (everything consumed) or to a value just ahead of it, to test the empty flag.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_DROP,
    S_FLUSH,
    S_FINAL
  } rx_state_e;

  // bytes an entry spans: header plus payload, rounded up to a dword
  function automatic logic [17:0] entry_span(input logic [15:0] n);
    return ({2'b00, n} + 18'd7) & ~18'd3;
  endfunction

endpackage

// File: rtl/rrb_fit_check.sv
module rrb_fit_check
  import rrb_pkg::*;
#(
  parameter int PTR_W = 11
)(
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W-1:0] mask,
  input  logic [15:0]      n_bytes,
  output logic             fits
);

  logic [PTR_W-1:0] gap;
  logic [PTR_W:0]   free;
  logic [17:0]      need;

  always_comb begin
    gap  = (rd_ptr - wr_ptr) & mask;
    free = (gap == '0) ? {1'b0, mask} + 1'b1 : {1'b0, gap};
    // one dword must stay free so full never looks like empty
    need = entry_span(n_bytes) + 18'd4;
    fits = (need <= 18'(free));
  end

endmodule

// File: rtl/rrb_rdptr.sv
module rrb_rdptr #(
  parameter int PTR_W = 11
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [15:0]      wdata,
  input  logic [PTR_W-1:0] mask,
  output logic [PTR_W-1:0] rd_q,
  output logic [PTR_W-1:0] rd_nxt
);

  logic [15:0] unbiased;

  always_comb begin
    unbiased = wdata + 16'd16;
    rd_nxt   = we ? (unbiased[PTR_W-1:0] & mask) : rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

endmodule

// File: rtl/rrb_lane_pack.sv
module rrb_lane_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word,
  output logic [3:0]  be
);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    if (g < 3) begin : g_store
      logic [7:0] acc_q;
      always_ff @(posedge clk) begin
        if (rst)                         acc_q <= '0;
        else if (take && lane == 2'(g))  acc_q <= din;
      end
      assign word[8*g +: 8] = (take && lane == 2'(g)) ? din : acc_q;
    end else begin : g_last
      assign word[8*g +: 8] = din;
    end
    assign be[g] = (2'(g) <= lane);
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rrb_pkg::*;
#(
  parameter  int BASE_BYTES = 256,
  localparam int LEN_MAX    = BASE_BYTES * 8,
  localparam int PTR_W      = $clog2(LEN_MAX),
  localparam int MEM_DWORDS = (LEN_MAX + 16) / 4,
  localparam int MEM_AW     = $clog2(MEM_DWORDS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        size_code,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [15:0]       rx_status,
  input  logic              rdp_we,
  input  logic [15:0]       rdp_wdata,
  input  logic              ovf_ack,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [15:0]       cur_addr,
  output logic              buf_empty,
  output logic              ovf_irq
);

  localparam logic [15:0] PLACEHOLDER = 16'hFFF0;

  rx_state_e        state_q;
  logic [PTR_W-1:0] wr_q, wr_nxt, rd_q, rd_nxt, size_mask, adv_ptr;
  logic [PTR_W-3:0] dw_mask, head_dw, data_dw;
  logic [15:0]      cnt_q, cnt_eff, idx, fin_status_q;
  logic             fits, take, ovf_set, in_frame, empty_q, ovf_q;
  logic [31:0]      pack_word;
  logic [3:0]       pack_be;
  logic [17:0]      span;

  always_comb begin
    size_mask = (PTR_W'(BASE_BYTES) << size_code) - PTR_W'(1);
    dw_mask   = size_mask[PTR_W-1:2];
    head_dw   = wr_q[PTR_W-1:2];
    cnt_eff   = (state_q == S_IDLE) ? 16'd0 : cnt_q;
    idx       = (state_q == S_FLUSH) ? cnt_q - 16'd1 : cnt_eff;
    data_dw   = (head_dw + (PTR_W-2)'(1) + idx[PTR_W-1:2]) & dw_mask;
    span      = entry_span(cnt_q);
    adv_ptr   = (wr_q + span[PTR_W-1:0]) & size_mask;
    in_frame  = (state_q == S_IDLE) || (state_q == S_RECV);
    take      = in_frame && rx_valid && fits;
    ovf_set   = in_frame && rx_valid && !fits;
    wr_nxt    = (state_q == S_FINAL) ? adv_ptr : wr_q;
  end

  rrb_fit_check #(.PTR_W(PTR_W)) u_fit (
    .wr_ptr  (wr_q),
    .rd_ptr  (rd_q),
    .mask    (size_mask),
    .n_bytes (cnt_eff + 16'd1),
    .fits    (fits)
  );

  rrb_rdptr #(.PTR_W(PTR_W)) u_rdptr (
    .clk    (clk),
    .rst    (rst),
    .we     (rdp_we),
    .wdata  (rdp_wdata),
    .mask   (size_mask),
    .rd_q   (rd_q),
    .rd_nxt (rd_nxt)
  );

  rrb_lane_pack u_pack (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .lane (idx[1:0]),
    .din  (rx_data),
    .word (pack_word),
    .be   (pack_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      wr_q         <= '0;
      cnt_q        <= '0;
      fin_status_q <= '0;
      empty_q      <= 1'b1;
      ovf_q        <= 1'b0;
      mem_we       <= 1'b0;
      mem_be       <= '0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
    end else begin
      mem_we  <= 1'b0;
      wr_q    <= wr_nxt;
      empty_q <= (wr_nxt == rd_nxt);
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_ack) ovf_q <= 1'b0;

      case (state_q)
        S_IDLE: begin
          if (take) begin
            mem_we    <= 1'b1;
            mem_be    <= 4'hF;
            mem_addr  <= MEM_AW'(head_dw);
            mem_wdata <= {PLACEHOLDER, 16'h0000};
            cnt_q     <= 16'd1;
            if (rx_last) begin
              fin_status_q <= rx_status;
              state_q      <= S_FLUSH;
            end else begin
              state_q <= S_RECV;
            end
          end else if (ovf_set && !rx_last) begin
            state_q <= S_DROP;
          end
        end
        S_RECV: begin
          if (take) begin
            cnt_q <= cnt_q + 16'd1;
            if (idx[1:0] == 2'd3 || rx_last) begin
              mem_we    <= 1'b1;
              mem_be    <= pack_be;
              mem_addr  <= MEM_AW'(data_dw);
              mem_wdata <= pack_word;
            end
            if (rx_last) begin
              fin_status_q <= rx_status;
              state_q      <= S_FINAL;
            end
          end else if (ovf_set) begin
            state_q <= rx_last ? S_IDLE : S_DROP;
          end
        end
        S_DROP: begin
          if (rx_valid && rx_last) state_q <= S_IDLE;
        end
        S_FLUSH: begin
          mem_we    <= 1'b1;
          mem_be    <= pack_be;
          mem_addr  <= MEM_AW'(data_dw);
          mem_wdata <= pack_word;
          state_q   <= S_FINAL;
        end
        S_FINAL: begin
          mem_we    <= 1'b1;
          mem_be    <= 4'hF;
          mem_addr  <= MEM_AW'(head_dw);
          mem_wdata <= {cnt_q, fin_status_q};
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cur_addr  = 16'(wr_q);
  assign buf_empty = empty_q;
  assign ovf_irq   = ovf_q;

  // R5: entries start on dword boundaries
  a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
    cur_addr[1:0] == 2'b00);

  // R5: the write pointer only moves once the header rewrite has been issued
  a_r5_advance_after_final: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_addr) |-> $past(state_q) == S_FINAL);

  // R3: first accepted byte leads to a full placeholder header write
  a_r3_placeholder: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && take) |=> (mem_we && mem_be == 4'hF && mem_wdata[31:16] == 16'hFFF0));

  // R7: empty flag agrees with the two pointer registers
  a_r7_empty: assert property (@(posedge clk) disable iff (rst)
    buf_empty == (wr_q == rd_q));

  // R8: a dropped frame writes nothing further
  a_r8_drop_silent: assert property (@(posedge clk) disable iff (rst)
    state_q == S_DROP |-> !mem_we);

  // R9: overflow flag holds until acknowledged
  a_r9_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (ovf_irq && !ovf_ack) |=> ovf_irq);

  // R10: input gap assumption while the tail of a frame is written
  a_r10_gap: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_FLUSH || state_q == S_FINAL) |-> !rx_valid);

endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;

  localparam int BASE_BYTES = 256;
  localparam int LEN_MAX    = BASE_BYTES * 8;
  localparam int MEM_DWORDS = (LEN_MAX + 16) / 4;
  localparam int MEM_AW     = $clog2(MEM_DWORDS);

  // {length, status, seed}
  localparam logic [39:0] VEC [0:5] = '{
    {16'd60,  16'h0001, 8'h10},
    {16'd17,  16'h0004, 8'h20},
    {16'd64,  16'h2001, 8'h30},
    {16'd7,   16'h0012, 8'h40},
    {16'd100, 16'h4001, 8'h50},
    {16'd33,  16'h0020, 8'h70}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        size_code = 2'd0;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              rx_last = 1'b0;
  logic [15:0]       rx_status = '0;
  logic              rdp_we = 1'b0;
  logic [15:0]       rdp_wdata = '0;
  logic              ovf_ack = 1'b0;
  logic              mem_we;
  logic [3:0]        mem_be;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [15:0]       cur_addr;
  logic              buf_empty;
  logic              ovf_irq;

  int total = 0;
  int bad   = 0;
  int exp_cur = 0;
  int blen = 256;
  bit done = 1'b0;
  logic [31:0] mdl [MEM_DWORDS];

  always #5 clk = ~clk;

  rx_ring_writer #(.BASE_BYTES(BASE_BYTES)) u_rx_ring_writer (
    .clk, .rst, .size_code, .rx_valid, .rx_data, .rx_last, .rx_status,
    .rdp_we, .rdp_wdata, .ovf_ack, .mem_we, .mem_be, .mem_addr, .mem_wdata,
    .cur_addr, .buf_empty, .ovf_irq
  );

  // behavioural RAM
  always @(posedge clk) begin
    if (mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mdl[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
  end

  function automatic logic [7:0] mbyte(input int a);
    return mdl[a / 4][8*(a % 4) +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0; rdp_we = 1'b0; ovf_ack = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input bit last, input logic [15:0] st);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_status = st;
  endtask

  task automatic send_frame(input int len, input logic [15:0] st, input logic [7:0] seed);
    for (int i = 0; i < len; i++) put_byte(8'(seed + i), i == len - 1, st);
    idle(2);
  endtask

  task automatic host_rd(input int v);
    @(negedge clk);
    rx_valid = 1'b0; rdp_we = 1'b1; rdp_wdata = 16'(v);
    @(negedge clk);
    rdp_we = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst = 1'b1; size_code = code;
    idle(3);
    rst = 1'b0;
    exp_cur = 0;
    blen = BASE_BYTES << code;
  endtask

  task automatic check_entry(input int head, input int len, input logic [15:0] st,
                             input logic [7:0] seed, input string req);
    logic [31:0] hdr;
    int badi;
    hdr = {mbyte((head + 3) % blen), mbyte((head + 2) % blen), mbyte((head + 1) % blen), mbyte(head)};
    check(hdr == {16'(len), st}, {req, " header"}, hdr, {16'(len), st});
    badi = -1;
    for (int i = 0; i < len; i++)
      if (badi < 0 && mbyte((head + 4 + i) % blen) !== 8'(seed + i)) badi = i;
    check(badi < 0, {req, " payload"}, (badi < 0) ? 32'd0 : 32'(mbyte((head + 4 + badi) % blen)),
          (badi < 0) ? 32'd0 : 32'(8'(seed + badi)));
  endtask

  function automatic int advance(input int cur, input int len);
    return (cur + ((len + 7) & ~3)) % blen;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int head;
    logic [31:0] saved;
    for (int i = 0; i < MEM_DWORDS; i++) mdl[i] = '0;

    // R1 reset state
    do_reset(2'd0);
    @(negedge clk);
    check(cur_addr == 16'd0, "R1 cur_addr", 32'(cur_addr), 0);
    check(buf_empty == 1'b1 && ovf_irq == 1'b0 && mem_we == 1'b0, "R1 flags",
          {29'd0, buf_empty, ovf_irq, mem_we}, 32'd4);

    // R3 placeholder visible mid-frame, pointer not yet moved (R5)
    put_byte(8'hA0, 1'b0, 16'h0);
    put_byte(8'hA1, 1'b0, 16'h0);
    idle(2);
    check(mdl[0] == 32'hFFF0_0000, "R3 placeholder", mdl[0], 32'hFFF0_0000);
    check(cur_addr == 16'd0 && buf_empty, "R5 no early advance", 32'(cur_addr), 0);
    for (int i = 2; i < 9; i++) put_byte(8'(8'hA0 + i), i == 8, 16'h0001);
    idle(5);
    check_entry(0, 9, 16'h0001, 8'hA0, "R5");
    exp_cur = advance(0, 9);
    check(cur_addr == 16'(exp_cur), "R5 advance", 32'(cur_addr), 32'(exp_cur));

    // table of frames: R4 R5 R11, wrap at 256 (R2), host consume (R6)
    for (int v = 0; v < 6; v++) begin
      int len;
      logic [15:0] st;
      logic [7:0] seed;
      len  = int'(VEC[v][39:24]);
      st   = VEC[v][23:8];
      seed = VEC[v][7:0];
      host_rd(exp_cur - 16);
      head = exp_cur;
      send_frame(len, st, seed);
      idle(3);
      check_entry(head, len, st, seed, "R4 R11 table");
      exp_cur = advance(head, len);
      check(cur_addr == 16'(exp_cur), "R5 table advance", 32'(cur_addr), 32'(exp_cur));
    end

    // R6 / R7 read pointer bias and empty flag
    host_rd(exp_cur - 12);
    check(buf_empty == 1'b0, "R6 R7 not empty", 32'(buf_empty), 0);
    host_rd(exp_cur - 16);
    check(buf_empty == 1'b1, "R6 R7 empty", 32'(buf_empty), 1);

    // R12 one-byte frame, then R10 frame after the minimum gap
    head = exp_cur;
    send_frame(1, 16'h0001, 8'hC3);
    send_frame(10, 16'h0008, 8'hD0);
    idle(3);
    check_entry(head, 1, 16'h0001, 8'hC3, "R12");
    head = advance(head, 1);
    check_entry(head, 10, 16'h0008, 8'hD0, "R10");
    exp_cur = advance(head, 10);
    check(cur_addr == 16'(exp_cur), "R10 R12 advance", 32'(cur_addr), 32'(exp_cur));

    // R8 overflow: 249 bytes cannot fit an empty 256-byte ring
    host_rd(exp_cur - 16);
    send_frame(249, 16'h0001, 8'h00);
    idle(3);
    check(cur_addr == 16'(exp_cur), "R8 pointer kept", 32'(cur_addr), 32'(exp_cur));
    check(ovf_irq == 1'b1 && buf_empty == 1'b1, "R8 flag", {30'd0, ovf_irq, buf_empty}, 32'd3);
    idle(4);
    check(ovf_irq == 1'b1, "R9 hold", 32'(ovf_irq), 1);
    @(negedge clk); ovf_ack = 1'b1;
    @(negedge clk); ovf_ack = 1'b0;
    check(ovf_irq == 1'b0, "R9 ack", 32'(ovf_irq), 0);

    // R8 exact fit: 248 bytes leave exactly one dword
    head = exp_cur;
    send_frame(248, 16'h0001, 8'h11);
    idle(3);
    check_entry(head, 248, 16'h0001, 8'h11, "R8 exact fit");
    exp_cur = advance(head, 248);
    check(cur_addr == 16'(exp_cur) && !ovf_irq && !buf_empty, "R8 fit flags",
          32'(cur_addr), 32'(exp_cur));

    // R8 no room: first byte refused, RAM untouched
    saved = mdl[exp_cur / 4];
    send_frame(1, 16'h0001, 8'h5A);
    idle(3);
    check(mdl[exp_cur / 4] == saved, "R8 no write", mdl[exp_cur / 4], saved);
    check(cur_addr == 16'(exp_cur) && ovf_irq, "R8 refused", 32'(cur_addr), 32'(exp_cur));

    // R2 larger ring: code 1 gives 512 bytes
    do_reset(2'd1);
    send_frame(300, 16'h0001, 8'h21);
    idle(3);
    check(cur_addr == 16'd304 && !ovf_irq, "R2 code1 accept", 32'(cur_addr), 32'd304);
    check_entry(0, 300, 16'h0001, 8'h21, "R2");
    exp_cur = 304;
    host_rd(exp_cur - 16);
    send_frame(200, 16'h0001, 8'h31);
    idle(3);
    exp_cur = advance(304, 200);
    check(cur_addr == 16'(exp_cur), "R2 advance", 32'(cur_addr), 32'(exp_cur));
    host_rd(exp_cur - 16);
    head = exp_cur;
    send_frame(10, 16'h0003, 8'h41);
    idle(3);
    check_entry(head, 10, 16'h0003, 8'h41, "R2 wrap");
    exp_cur = advance(head, 10);
    check(cur_addr == 16'(exp_cur), "R2 wrap advance", 32'(cur_addr), 32'(exp_cur));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule